// File: doc/BRIEF.md
# Nested Priority Preemption Controller

This block gives a reactive processor core up to four nested preemption regions, resolved in hardware. Arming a region takes two commands. A load command latches a continuation address. An arm command then binds that address to one of sixteen single-bit trigger lines and to a strong or weak mode, at the next free nesting level. The lines are twelve external signals plus four timer-overflow lines.

Trigger lines are looked at only when the tick-boundary pulse is high. If an armed level sees its trigger, the outermost such level wins. The block then tells the fetch unit to jump to that level's continuation address. No context is saved or restored.

A strong region redirects at once, so its body gets no control in the triggering tick. A weak region lets its body run through that tick and redirects at the next tick pulse. When a level fires, it and every level inside it are disarmed. Outputs that a dropped body sustained are cleared when the redirect is issued. The same clearing happens when the innermost body ends normally through a release command.

Top module: `nest_preempt_ctrl`

## Requirements
- R1: Up to four levels can be armed at once. Each arm command fills the next free level, inward from level 0, the outermost.
- R2: A load command (cmd_op=1) latches cmd_addr. A later arm command stores the latched address into the level it arms. Loads after the arm do not change an armed level's address.
- R3: cmd_sel picks the trigger line. Values 0 to 11 select sig_ext[0] to sig_ext[11]. Values 12 to 15 select sig_tmr[0] to sig_tmr[3].
- R4: Trigger lines are sampled only in a cycle where tick is 1. A trigger that is high while tick is 0 has no effect.
- R5: If the triggers of several armed levels are present at the same tick, only the outermost of them is redirected to.
- R6: A strong level (armed with cmd_op=2) that fires at a tick raises redirect_valid for exactly one cycle, in the cycle after that tick. redirect_addr carries the level's address in that cycle.
- R7: A weak level (armed with cmd_op=3) that fires gives no redirect after that tick. It redirects one cycle after the next tick pulse, unless a strong outer level fires at that same tick. In that case only the outer address is issued.
- R8: When a level fires, it and all levels inside it are disarmed. All levels outside it stay armed.
- R9: A release command (cmd_op=4) disarms the innermost armed level. Release is ignored when no level is armed, or when a level fires in the same cycle.
- R10: An arm command while four levels are armed is ignored. It sets ovf_err, which stays 1 until reset.
- R11: A sustain command (cmd_op=5) sets the sus_out bits given in cmd_mask. Each bit is owned by the body of the innermost armed level. A bit stays 1 until its owning body is dropped, either by the redirect of a level that encloses it or by release. Bits set with no level armed stay set until reset.
- R12: An arm command in the same cycle as a firing tick takes effect after the disarm of R8. It occupies the level the firing freed.
- R13: After reset, no level is armed and redirect_valid, sus_out and ovf_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 none, 1 load, 2 arm strong, 3 arm weak, 4 release, 5 sustain |
| cmd_addr | input | 13 | Continuation address for load |
| cmd_sel | input | 4 | Trigger line index for arm |
| cmd_mask | input | 8 | Output bits for sustain |
| tick | input | 1 | Tick-boundary pulse |
| sig_ext | input | 12 | External trigger lines |
| sig_tmr | input | 4 | Timer-overflow trigger lines |
| redirect_valid | output | 1 | Jump request to the fetch unit |
| redirect_addr | output | 13 | Jump target |
| sus_out | output | 8 | Sustained outputs |
| ovf_err | output | 1 | Sticky nesting overflow flag |

## Verification
Two functions can fall in the same cycle, and both cases are provoked on purpose.

The first is a firing tick together with a command. An arm in that cycle must land in the level the firing just freed. A release in that cycle must be ignored. The bench judges both by what a later tick redirects to.

The second is a due weak redirect meeting a stronger outer trigger. The bench checks that only the outer address leaves the block, and that sustained bits owned by the dropped bodies vanish in the same cycle as the redirect.

// File: rtl/np_pkg.sv
package np_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_LOAD       = 3'd1,
    OP_ARM_STRONG = 3'd2,
    OP_ARM_WEAK   = 3'd3,
    OP_RELEASE    = 3'd4,
    OP_SUSTAIN    = 3'd5
  } np_op_e;
endpackage

// File: rtl/np_level_stack.sv
// Per-level storage of armed preemption regions, filled inward from level 0.
module np_level_stack #(
  parameter int LEVELS  = 4,
  parameter int ADDR_W  = 13,
  parameter int SEL_W   = 4,
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cut_en,
  input  logic [DEPTH_W-1:0] cut_lvl,
  input  logic               push_en,
  input  logic [ADDR_W-1:0]  push_addr,
  input  logic [SEL_W-1:0]   push_sel,
  input  logic               push_weak,
  input  logic               pop_en,
  output logic [DEPTH_W-1:0] depth,
  output logic [DEPTH_W-1:0] depth_base,
  output logic [LEVELS-1:0]  lvl_valid,
  output logic [LEVELS-1:0]  lvl_weak,
  output logic [ADDR_W-1:0]  lvl_addr [LEVELS],
  output logic [SEL_W-1:0]   lvl_sel  [LEVELS]
);
  logic [DEPTH_W-1:0] depth_q;
  logic [DEPTH_W-1:0] depth_d;

  assign depth_base = cut_en ? cut_lvl : depth_q;
  assign depth      = depth_q;

  always_comb begin
    if (push_en)     depth_d = depth_base + DEPTH_W'(1);
    else if (pop_en) depth_d = depth_q - DEPTH_W'(1);
    else             depth_d = depth_base;
  end

  always_ff @(posedge clk) begin
    if (rst) depth_q <= '0;
    else     depth_q <= depth_d;
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    logic [ADDR_W-1:0] addr_q;
    logic [SEL_W-1:0]  sel_q;
    logic              weak_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
        sel_q  <= '0;
        weak_q <= 1'b0;
      end else if (push_en && depth_base == DEPTH_W'(i)) begin
        addr_q <= push_addr;
        sel_q  <= push_sel;
        weak_q <= push_weak;
      end
    end

    assign lvl_valid[i] = depth_q > DEPTH_W'(i);
    assign lvl_weak[i]  = weak_q;
    assign lvl_addr[i]  = addr_q;
    assign lvl_sel[i]   = sel_q;
  end
endmodule

// File: rtl/np_prio_pick.sv
// Finds the outermost armed level whose trigger line is present.
module np_prio_pick #(
  parameter int LEVELS = 4,
  parameter int SEL_W  = 4,
  parameter int NSIG   = 16,
  parameter int IDX_W  = 2
) (
  input  logic [LEVELS-1:0] lvl_valid,
  input  logic [SEL_W-1:0]  lvl_sel [LEVELS],
  input  logic [NSIG-1:0]   sig,
  output logic              hit,
  output logic [IDX_W-1:0]  win
);
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (lvl_valid[i] && sig[lvl_sel[i]]) begin
        hit = 1'b1;
        win = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/np_sustain_bank.sv
// Sustained outputs, each tagged with the nesting depth of the body that set it.
module np_sustain_bank #(
  parameter int OUT_W   = 8,
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_en,
  input  logic [DEPTH_W-1:0] clr_from,
  input  logic [OUT_W-1:0]   set_mask,
  input  logic [DEPTH_W-1:0] set_owner,
  output logic [OUT_W-1:0]   sus_out
);
  for (genvar b = 0; b < OUT_W; b++) begin : g_bit
    logic               on_q;
    logic [DEPTH_W-1:0] owner_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        on_q    <= 1'b0;
        owner_q <= '0;
      end else if (set_mask[b]) begin
        on_q    <= 1'b1;
        owner_q <= set_owner;
      end else if (clr_en && owner_q >= clr_from) begin
        on_q    <= 1'b0;
      end
    end

    assign sus_out[b] = on_q;
  end
endmodule

// File: rtl/nest_preempt_ctrl.sv
module nest_preempt_ctrl #(
  parameter int LEVELS   = 4,
  parameter int ADDR_W   = 13,
  parameter int EXT_SIGS = 12,
  parameter int TMR_SIGS = 4,
  parameter int OUT_W    = 8,
  localparam int NSIG    = EXT_SIGS + TMR_SIGS,
  localparam int SEL_W   = $clog2(NSIG),
  localparam int DEPTH_W = $clog2(LEVELS + 1),
  localparam int IDX_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [OUT_W-1:0]  cmd_mask,
  input  logic              tick,
  input  logic [EXT_SIGS-1:0] sig_ext,
  input  logic [TMR_SIGS-1:0] sig_tmr,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic [OUT_W-1:0]  sus_out,
  output logic              ovf_err
);
  import np_pkg::*;

  np_op_e op;
  assign op = cmd_valid ? np_op_e'(cmd_op) : OP_NOP;

  logic [NSIG-1:0] sig_all;
  assign sig_all = {sig_tmr, sig_ext};

  // Stack state
  logic [DEPTH_W-1:0] stk_depth, depth_base;
  logic [LEVELS-1:0]  lvl_valid, lvl_weak;
  logic [ADDR_W-1:0]  lvl_addr [LEVELS];
  logic [SEL_W-1:0]   lvl_sel  [LEVELS];

  // Priority result
  logic             hit;
  logic [IDX_W-1:0] win;

  // Pending weak redirect
  logic               pend_v;
  logic [DEPTH_W-1:0] pend_lvl;
  logic [ADDR_W-1:0]  pend_addr;

  logic [ADDR_W-1:0] addr_latch;

  logic tick_hit, fire_strong, fire_weak, pend_due, redirect_d;
  logic arm_cmd, push_en, pop_en, ovf_set;
  logic [DEPTH_W-1:0] win_d;
  logic [ADDR_W-1:0]  redirect_addr_d;
  logic               clr_en;
  logic [DEPTH_W-1:0] clr_from;
  logic [OUT_W-1:0]   set_mask;

  np_prio_pick #(
    .LEVELS(LEVELS), .SEL_W(SEL_W), .NSIG(NSIG), .IDX_W(IDX_W)
  ) i_pick (
    .lvl_valid(lvl_valid),
    .lvl_sel  (lvl_sel),
    .sig      (sig_all),
    .hit      (hit),
    .win      (win)
  );

  assign win_d       = DEPTH_W'(win);
  assign tick_hit    = tick && hit;
  assign fire_strong = tick_hit && !lvl_weak[win];
  assign fire_weak   = tick_hit &&  lvl_weak[win];
  assign pend_due    = tick && pend_v && !fire_strong;
  assign redirect_d  = fire_strong || pend_due;
  assign redirect_addr_d = fire_strong ? lvl_addr[win] : pend_addr;

  assign arm_cmd = (op == OP_ARM_STRONG) || (op == OP_ARM_WEAK);
  assign push_en = arm_cmd && (depth_base < DEPTH_W'(LEVELS));
  assign ovf_set = arm_cmd && (depth_base == DEPTH_W'(LEVELS));
  assign pop_en  = (op == OP_RELEASE) && !tick_hit && (stk_depth != '0);

  np_level_stack #(
    .LEVELS(LEVELS), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DEPTH_W(DEPTH_W)
  ) i_stack (
    .clk       (clk),
    .rst       (rst),
    .cut_en    (tick_hit),
    .cut_lvl   (win_d),
    .push_en   (push_en),
    .push_addr (addr_latch),
    .push_sel  (cmd_sel),
    .push_weak (op == OP_ARM_WEAK),
    .pop_en    (pop_en),
    .depth     (stk_depth),
    .depth_base(depth_base),
    .lvl_valid (lvl_valid),
    .lvl_weak  (lvl_weak),
    .lvl_addr  (lvl_addr),
    .lvl_sel   (lvl_sel)
  );

  // Shallowest owner depth whose sustained bits must drop this cycle.
  always_comb begin
    clr_en   = 1'b0;
    clr_from = '1;
    if (fire_strong) begin
      clr_en   = 1'b1;
      clr_from = win_d + DEPTH_W'(1);
    end
    if (pend_due && (!clr_en || (pend_lvl + DEPTH_W'(1)) < clr_from)) begin
      clr_en   = 1'b1;
      clr_from = pend_lvl + DEPTH_W'(1);
    end
    if (pop_en && (!clr_en || stk_depth < clr_from)) begin
      clr_en   = 1'b1;
      clr_from = stk_depth;
    end
  end

  assign set_mask = (op == OP_SUSTAIN) ? cmd_mask : '0;

  np_sustain_bank #(
    .OUT_W(OUT_W), .DEPTH_W(DEPTH_W)
  ) i_sus (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (clr_en),
    .clr_from (clr_from),
    .set_mask (set_mask),
    .set_owner(depth_base),
    .sus_out  (sus_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_latch     <= '0;
      pend_v         <= 1'b0;
      pend_lvl       <= '0;
      pend_addr      <= '0;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
      ovf_err        <= 1'b0;
    end else begin
      if (op == OP_LOAD) addr_latch <= cmd_addr;

      if (fire_weak) begin
        pend_v    <= 1'b1;
        pend_lvl  <= win_d;
        pend_addr <= lvl_addr[win];
      end else if (fire_strong || pend_due) begin
        pend_v <= 1'b0;
      end

      redirect_valid <= redirect_d;
      if (redirect_d) redirect_addr <= redirect_addr_d;

      if (ovf_set) ovf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/np_checker.sv
module np_checker #(
  parameter int LEVELS  = 4,
  parameter int OUT_W   = 8,
  parameter int DEPTH_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [2:0]         cmd_op,
  input logic               tick,
  input logic               redirect_valid,
  input logic [OUT_W-1:0]   sus_out,
  input logic               ovf_err,
  input logic [DEPTH_W-1:0] depth
);
  import np_pkg::*;

  logic arm_now;
  assign arm_now = cmd_valid && (cmd_op == OP_ARM_STRONG || cmd_op == OP_ARM_WEAK);

  assert_depth_bound_R1: assert property (@(posedge clk) disable iff (rst)
    depth <= DEPTH_W'(LEVELS));

  assert_redirect_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> $past(tick));

  assert_depth_grows_by_arm_R1: assert property (@(posedge clk) disable iff (rst)
    (depth > $past(depth)) |-> ($past(arm_now) && depth == $past(depth) + DEPTH_W'(1)));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> ($past(arm_now) && $past(depth) == DEPTH_W'(LEVELS)));

  assert_sus_rise_by_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    ((sus_out & ~$past(sus_out)) != '0) |-> $past(cmd_valid && cmd_op == OP_SUSTAIN));
endmodule

bind nest_preempt_ctrl np_checker #(
  .LEVELS(LEVELS), .OUT_W(OUT_W), .DEPTH_W(DEPTH_W)
) i_np_checker (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .tick          (tick),
  .redirect_valid(redirect_valid),
  .sus_out       (sus_out),
  .ovf_err       (ovf_err),
  .depth         (stk_depth)
);

// File: tb/test_nest_preempt_ctrl.sv
`timescale 1ns/1ps
module test_nest_preempt_ctrl;
  import np_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [12:0] cmd_addr = '0;
  logic [3:0]  cmd_sel = '0;
  logic [7:0]  cmd_mask = '0;
  logic        tick = 1'b0;
  logic [11:0] sig_ext = '0;
  logic [3:0]  sig_tmr = '0;
  logic        redirect_valid;
  logic [12:0] redirect_addr;
  logic [7:0]  sus_out;
  logic        ovf_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [12:0] exp_q[$];

  always #5 clk = ~clk;

  nest_preempt_ctrl i_nest_preempt_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_sel(cmd_sel), .cmd_mask(cmd_mask),
    .tick(tick), .sig_ext(sig_ext), .sig_tmr(sig_tmr),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .sus_out(sus_out), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every redirect is compared against the scoreboard (R5 R6 R7).
  always @(negedge clk) begin
    if (!rst && !done && redirect_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R6 actual=%0h expected=none", redirect_addr);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        if (redirect_addr !== e) begin
          failures++;
          $display("FAIL R5 actual=%0h expected=%0h", redirect_addr, e);
        end
      end
    end
  end

  // Driver: one clock per call, inputs changed at the falling edge.
  task automatic step(input np_op_e op, input logic [12:0] a, input logic [3:0] s,
                      input logic [7:0] m, input logic t, input logic [15:0] sg);
    cmd_valid = (op != OP_NOP);
    cmd_op    = op;
    cmd_addr  = a;
    cmd_sel   = s;
    cmd_mask  = m;
    tick      = t;
    sig_ext   = sg[11:0];
    sig_tmr   = sg[15:12];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; tick = 1'b0; sig_ext = '0; sig_tmr = '0;
  endtask

  function automatic logic [15:0] ln(input int n);
    return 16'(1) << n;
  endfunction

  task automatic load(input logic [12:0] a);  step(OP_LOAD, a, 0, 0, 0, 0); endtask
  task automatic arm_s(input logic [3:0] s);  step(OP_ARM_STRONG, 0, s, 0, 0, 0); endtask
  task automatic arm_w(input logic [3:0] s);  step(OP_ARM_WEAK, 0, s, 0, 0, 0); endtask
  task automatic sustain(input logic [7:0] m); step(OP_SUSTAIN, 0, 0, m, 0, 0); endtask
  task automatic tk(input logic [15:0] sg);   step(OP_NOP, 0, 0, 0, 1, sg); endtask
  task automatic idle();                      step(OP_NOP, 0, 0, 0, 0, 0); endtask
  task automatic expect_rd(input logic [12:0] a); exp_q.push_back(a); endtask
  task automatic drained(input string req);
    idle(); idle();
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk(redirect_valid == 0 && sus_out == 0 && ovf_err == 0, "R13",
        {redirect_valid, sus_out, ovf_err}, 0);

    // R6 R4 R3 strong level on external line 3
    load(13'h100); arm_s(4'd3);
    tk(0);
    step(OP_NOP, 0, 0, 0, 0, ln(3));            // R4: no tick, no effect
    chk(redirect_valid == 0, "R4", redirect_valid, 0);
    expect_rd(13'h100); tk(ln(3));
    chk(redirect_valid == 1 && redirect_addr == 13'h100, "R6", redirect_addr, 13'h100);
    idle();
    chk(redirect_valid == 0, "R6", redirect_valid, 0);
    tk(ln(3));                                   // R8: level gone
    drained("R8");

    // R3 timer line: sel 13 -> sig_tmr[1]
    load(13'h200); arm_s(4'd13);
    expect_rd(13'h200); tk(ln(13));
    drained("R3");

    // R5 R8 R2 priority among three strong levels
    load(13'h010); arm_s(4'd0);
    load(13'h020); arm_s(4'd1);
    load(13'h030); arm_s(4'd2);
    load(13'h040);                               // R2: does not alter armed levels
    expect_rd(13'h020); tk(ln(1) | ln(2));
    tk(ln(2));                                   // R8: inner level dropped
    expect_rd(13'h010); tk(ln(0));               // R8: outer level kept
    drained("R5");

    // R7 weak redirect one tick later
    load(13'h050); arm_w(4'd4);
    tk(ln(4));
    idle();
    chk(redirect_valid == 0, "R7", redirect_valid, 0);
    expect_rd(13'h050); tk(0);
    drained("R7");

    // R7 outer strong overrides a pending weak
    load(13'h060); arm_s(4'd5);
    load(13'h070); arm_w(4'd6);
    tk(ln(6));
    expect_rd(13'h060); tk(ln(5));
    tk(0);
    drained("R7");

    // R11 sustained outputs and their owners
    sustain(8'h01);
    load(13'h080); arm_s(4'd7);
    sustain(8'h02);
    load(13'h090); arm_w(4'd8);
    sustain(8'h04);
    chk(sus_out == 8'h07, "R11", sus_out, 8'h07);
    tk(ln(8));
    chk(sus_out == 8'h07, "R11", sus_out, 8'h07);  // weak body still alive
    expect_rd(13'h090); tk(0);
    chk(sus_out == 8'h03, "R11", sus_out, 8'h03);
    expect_rd(13'h080); tk(ln(7));
    chk(sus_out == 8'h01, "R11", sus_out, 8'h01);
    drained("R11");

    // R9 release
    load(13'h0A0); arm_s(4'd9);
    sustain(8'h10);
    chk(sus_out == 8'h11, "R11", sus_out, 8'h11);
    step(OP_RELEASE, 0, 0, 0, 0, 0);
    chk(sus_out == 8'h01, "R9", sus_out, 8'h01);
    tk(ln(9));
    step(OP_RELEASE, 0, 0, 0, 0, 0);             // nothing armed: ignored
    chk(sus_out == 8'h01, "R9", sus_out, 8'h01);
    drained("R9");

    // R9 release in a firing cycle is ignored
    load(13'h0B0); arm_s(4'd10);
    load(13'h0C0); arm_s(4'd11);
    expect_rd(13'h0C0); step(OP_RELEASE, 0, 0, 0, 1, ln(11));
    expect_rd(13'h0B0); tk(ln(10));
    drained("R9");

    // R12 arm in the same cycle as a firing tick
    load(13'h0D0); arm_s(4'd0);
    load(13'h0E0);
    expect_rd(13'h0D0); step(OP_ARM_STRONG, 0, 4'd1, 0, 1, ln(0));
    expect_rd(13'h0E0); tk(ln(1));
    drained("R12");

    // R10 R1 overflow on fifth arm
    load(13'h111); arm_s(4'd0);
    load(13'h122); arm_s(4'd1);
    load(13'h133); arm_s(4'd2);
    load(13'h144); arm_s(4'd3);
    chk(ovf_err == 0, "R1", ovf_err, 0);
    load(13'h155); arm_s(4'd4);
    chk(ovf_err == 1, "R10", ovf_err, 1);
    tk(ln(4));                                   // ignored arm never fires
    expect_rd(13'h144); tk(ln(3));
    expect_rd(13'h111); tk(ln(0));
    drained("R10");
    chk(ovf_err == 1, "R10", ovf_err, 1);
    chk(sus_out == 8'h01, "R11", sus_out, 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule